// File: doc/BRIEF.md
# Streaming Command-Coded Byte Expander

This block rebuilds a configuration image from a compact command-coded byte stream while the stream is read. Each command byte selects one of four expansions: a run of zero bytes, a run of all-ones bytes, a block of literal bytes copied from the input, or a lookup into a 128-entry dictionary that yields one byte or a byte pair. A dedicated command value marks the end of the stream. Both sides are byte streams with valid/ready handshakes, so a slow consumer throttles the whole decode without loss.

The dictionary is filled through a plain write port while the block is not decoding. A `start` pulse moves the controller from its idle or finished state into command fetch; after the end marker it raises `done`, stops taking input and waits for the next `start`. The controller states are IDLE (after reset, writes allowed), FETCH (accept one command byte), RUN (emit the fill byte `count` times), LIT (forward input bytes one for one), DICT_HI (emit the selected entry's first byte), DICT_LO (emit the second byte of a pair entry) and DONE (stream finished, writes allowed). Transitions: IDLE or DONE go to FETCH on `start`; FETCH goes to RUN, LIT, DICT_HI or DONE by command class, or stays in FETCH on a no-op; RUN and LIT return to FETCH after their last beat; DICT_HI returns to FETCH for a single entry or goes to DICT_LO for a pair; DICT_LO returns to FETCH.

Top module: `cfg_unpacker`

## Requirements
- R1: After reset `in_ready`, `out_valid`, `busy` and `done` are all low, and no command is taken before a `start` pulse.
- R2: A command byte equal to 0x00 is consumed, `done` rises on the next cycle, and while `done` is high `in_ready` and `out_valid` stay low; a `start` pulse clears `done` and resumes command fetch.
- R3: A command with bits [7:5] = 001 and count n = bits [4:0] in 1..31 emits exactly n bytes of 0x00.
- R4: A command with bits [7:5] = 010 and count n in 1..31 emits exactly n bytes of 0xFF.
- R5: A command with bits [7:5] = 011 and count n in 1..31 forwards the next n input bytes unchanged in order, including bytes equal to 0x00, which are not read as commands.
- R6: A command with bit 7 set selects dictionary index bits [6:0]; an index below 96 emits one byte, bits [7:0] of the 16-bit entry.
- R7: An index of 96 or above emits two bytes on consecutive accepted beats: entry bits [15:8] first, then bits [7:0].
- R8: Run and literal commands with n = 0, and commands 0x01 to 0x1F, emit nothing; the next input byte is read as a command.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged on the next cycle; no byte is lost or repeated.
- R10: Dictionary writes are ignored while `busy` is high and take effect while the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin decoding from IDLE or DONE |
| dict_we | input | 1 | Dictionary write strobe |
| dict_waddr | input | 7 | Dictionary write index |
| dict_wdata | input | 16 | Dictionary entry value |
| in_valid | input | 1 | Compressed byte present |
| in_data | input | 8 | Compressed byte |
| in_ready | output | 1 | Compressed byte accepted this cycle when valid |
| out_valid | output | 1 | Expanded byte present |
| out_data | output | 8 | Expanded byte |
| out_ready | input | 1 | Consumer accepts expanded byte |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | End marker reached |

## Verification
The hold property on the output side presumes the producer keeps `in_valid` and `in_data` steady until its byte is taken, because literal bytes pass straight through to `out_data`; the bench driver only changes a byte after its handshake completes and inserts gaps only between bytes. The end-marker property presumes `start` is not pulsed while decoding, and the bench pulses it only in IDLE or DONE. Consumer backpressure is irregular, drawn from a shift register, so stalls hit runs, literal blocks and both halves of pair entries.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN,
        ST_LIT,
        ST_DICT_HI,
        ST_DICT_LO,
        ST_DONE
    } cfgu_state_e;

    // command class taken from bits [6:5] of a byte whose bit 7 is clear
    typedef enum logic [1:0] {
        CLS_NOP  = 2'b00,
        CLS_ZERO = 2'b01,
        CLS_ONES = 2'b10,
        CLS_LIT  = 2'b11
    } cfgu_class_e;

endpackage

// File: rtl/cfgu_dict.sv
module cfgu_dict #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cfgu_ctrl.sv
module cfgu_ctrl
    import cfgu_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int SINGLE_CNT = 96,
    localparam int AW        = $clog2(DEPTH),
    localparam int DW        = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic [AW-1:0]     dict_raddr,
    input  logic [DW-1:0]     dict_rdata,
    output logic              busy,
    output logic              done
);

    cfgu_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             fill_ones, fill_ones_n;
    logic [AW-1:0]    idx, idx_n;

    logic [CNT_W-1:0] cmd_len;
    cfgu_class_e      cmd_cls;
    logic             idx_is_pair;

    assign cmd_len     = in_data[CNT_W-1:0];
    assign cmd_cls     = cfgu_class_e'(in_data[6:5]);
    assign idx_is_pair = (int'(idx) >= SINGLE_CNT);
    assign dict_raddr  = idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            fill_ones <= 1'b0;
            idx       <= '0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            fill_ones <= fill_ones_n;
            idx       <= idx_n;
        end
    end

    // next state
    always_comb begin
        state_n     = state;
        cnt_n       = cnt;
        fill_ones_n = fill_ones;
        idx_n       = idx;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) state_n = ST_FETCH;
            end
            ST_FETCH: begin
                if (in_valid) begin
                    if (in_data[BYTE_W-1]) begin
                        idx_n   = in_data[AW-1:0];
                        state_n = ST_DICT_HI;
                    end else if (in_data == '0) begin
                        state_n = ST_DONE;
                    end else if (cmd_len != '0) begin
                        cnt_n = cmd_len;
                        unique case (cmd_cls)
                            CLS_ZERO: begin fill_ones_n = 1'b0; state_n = ST_RUN; end
                            CLS_ONES: begin fill_ones_n = 1'b1; state_n = ST_RUN; end
                            CLS_LIT:  state_n = ST_LIT;
                            CLS_NOP:  state_n = ST_FETCH;
                        endcase
                    end
                end
            end
            ST_RUN: begin
                if (out_ready) begin
                    cnt_n = cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state_n = ST_FETCH;
                end
            end
            ST_LIT: begin
                if (in_valid && out_ready) begin
                    cnt_n = cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state_n = ST_FETCH;
                end
            end
            ST_DICT_HI: begin
                if (out_ready) state_n = idx_is_pair ? ST_DICT_LO : ST_FETCH;
            end
            ST_DICT_LO: begin
                if (out_ready) state_n = ST_FETCH;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_FETCH: in_ready = 1'b1;
            ST_RUN: begin
                out_valid = 1'b1;
                out_data  = {BYTE_W{fill_ones}};
            end
            ST_LIT: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
            end
            ST_DICT_HI: begin
                out_valid = 1'b1;
                out_data  = idx_is_pair ? dict_rdata[DW-1:BYTE_W] : dict_rdata[BYTE_W-1:0];
            end
            ST_DICT_LO: begin
                out_valid = 1'b1;
                out_data  = dict_rdata[BYTE_W-1:0];
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_unpacker.sv
module cfg_unpacker
    import cfgu_pkg::*;
#(
    parameter int DICT_DEPTH = 128,
    parameter int SINGLE_CNT = 96,
    localparam int AW        = $clog2(DICT_DEPTH),
    localparam int DW        = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dict_we,
    input  logic [AW-1:0]     dict_waddr,
    input  logic [DW-1:0]     dict_wdata,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done
);

    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_gate;

    assign wr_gate = dict_we && !busy;

    cfgu_dict #(
        .DEPTH (DICT_DEPTH),
        .WIDTH (DW)
    ) u_dict (
        .clk     (clk),
        .wr_en   (wr_gate),
        .wr_addr (dict_waddr),
        .wr_data (dict_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cfgu_ctrl #(
        .DEPTH      (DICT_DEPTH),
        .SINGLE_CNT (SINGLE_CNT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .dict_raddr (rd_addr),
        .dict_rdata (rd_data),
        .busy       (busy),
        .done       (done)
    );

endmodule

// File: rtl/cfg_unpacker_chk.sv
module cfg_unpacker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ready,
    input logic       busy,
    input logic       done
);

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("stalled output byte changed or vanished");

    // R2
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!in_ready && !out_valid))
        else $error("handshake active while done");

    // R2
    end_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_valid && in_ready && in_data == 8'h00))
        else $error("done rose without an end marker");

    // R10
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done))
        else $error("busy and done together");

endmodule

bind cfg_unpacker cfg_unpacker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/cfg_unpacker_bench.sv
module cfg_unpacker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dict_we = 1'b0;
    logic [6:0]  dict_waddr = '0;
    logic [15:0] dict_wdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] lfsr = 8'hB5;

    always #4 clk = ~clk;

    cfg_unpacker u_cfg_unpacker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dict_we(dict_we), .dict_waddr(dict_waddr), .dict_wdata(dict_wdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done)
    );

    // stream table: commands and literal bytes
    localparam int MAIN_N = 15;
    localparam logic [7:0] MAIN_IN [MAIN_N] = '{
        8'h23,               // R3: three zeros
        8'h42,               // R4: two 0xFF
        8'h63, 8'hAA, 8'h00, 8'hC3, // R5: literal block with an embedded 0x00
        8'h85,               // R6: single entry 5
        8'hE1,               // R7: pair entry 97
        8'h20, 8'h60, 8'h05, // R8: no-ops
        8'hFF,               // R7: pair entry 127
        8'hDF,               // R6: last single entry 95
        8'h25,               // R3: five zeros
        8'h00                // R2: end marker
    };
    localparam int MAIN_E = 19;
    localparam logic [7:0] MAIN_EXP [MAIN_E] = '{
        8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hAA, 8'h00, 8'hC3,
        8'h15, 8'h61, 8'h9E, 8'h7F, 8'h80, 8'h6F,
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00
    };

    logic [7:0] tx_q [$];
    logic [7:0] rx_q [$];

    // single entries hold index + 0x10 in the low byte; pairs hold {index, ~index}
    function automatic logic [15:0] entry_val(input int i);
        logic [7:0] b = 8'(i);
        return (i < 96) ? {8'h00, b + 8'h10} : {b, ~b};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic drive_all();
        for (int k = 0; k < tx_q.size(); k++) begin
            if (k % 3 == 2) begin
                @(negedge clk); in_valid = 1'b0;
            end
            @(negedge clk); in_valid = 1'b1; in_data = tx_q[k];
            #1;
            while (!in_ready) begin
                @(negedge clk); #1;
            end
            @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic collect(input string req);
        int got = 0;
        while (1) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = lfsr[0] | lfsr[2];
            #1;
            if (done) break;
            if (out_valid && out_ready) begin
                if (got < rx_q.size())
                    check(out_data == rx_q[got], req, out_data, rx_q[got]);
                else
                    check(1'b0, req, out_data, 0);
                got++;
            end
        end
        check(got == rx_q.size(), req, got, rx_q.size());
        out_ready = 1'b0;
    endtask

    task automatic dict_write(input int a, input logic [15:0] v);
        @(negedge clk);
        dict_we = 1'b1; dict_waddr = 7'(a); dict_wdata = v;
        @(negedge clk);
        dict_we = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1; in_data = 8'h23;
        repeat (2) @(negedge clk);
        #1;
        // R1: reset state, no fetch before start
        check(!in_ready && !out_valid, "R1", {in_ready, out_valid}, 0);
        check(!busy && !done, "R1", {busy, done}, 0);
        in_valid = 1'b0;

        for (int i = 0; i < 128; i++) dict_write(i, entry_val(i));

        // table-driven stream walk (R3 R4 R5 R6 R7 R8 R9)
        pulse_start();
        tx_q.delete(); rx_q.delete();
        foreach (MAIN_IN[k])  tx_q.push_back(MAIN_IN[k]);
        foreach (MAIN_EXP[k]) rx_q.push_back(MAIN_EXP[k]);
        fork
            drive_all();
            collect("R3-R9 table");
        join

        // R2: done holds the block quiet
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h23;
        for (int c = 0; c < 3; c++) begin
            out_ready = 1'b1;
            #1;
            check(done && !in_ready && !out_valid, "R2", {done, in_ready, out_valid}, 3'b100);
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b0;

        // R2 restart, R4 max run of 31, R10 write while busy ignored
        pulse_start();
        #1;
        check(!done && busy, "R2", {done, busy}, 2'b01);
        tx_q.delete(); rx_q.delete();
        tx_q.push_back(8'h5F); tx_q.push_back(8'h85); tx_q.push_back(8'h00);
        for (int k = 0; k < 31; k++) rx_q.push_back(8'hFF);
        rx_q.push_back(8'h15);
        fork
            drive_all();
            collect("R4/R10");
            begin
                repeat (4) @(negedge clk);
                dict_write(5, 16'hBEEF);
            end
        join

        // R10: write while done takes effect; R3 max run of 31 zeros
        dict_write(5, 16'h0042);
        pulse_start();
        tx_q.delete(); rx_q.delete();
        tx_q.push_back(8'h3F); tx_q.push_back(8'h85); tx_q.push_back(8'h00);
        for (int k = 0; k < 31; k++) rx_q.push_back(8'h00);
        rx_q.push_back(8'h42);
        fork
            drive_all();
            collect("R3/R10");
        join

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule